// File: doc/BRIEF.md
# Split Dual Row Buffer Controller

This block runs the row buffering of one multi-level-cell memory bank as two half-size buffers instead of one large one. One half holds the open row of the fast-read bit plane and the other holds the open row of the fast-write bit plane. The two halves together use the same storage as one conventional buffer. Because each half tracks its own open row, a fast-read row and a fast-write row can be open at the same time.

Each request carries a row, a bit class and a column. The block checks only the half that matches the request's class. On a hit it goes straight to the access. On a miss it issues commands for that half only. If the half was empty it sends an activate. If the half held another row it sends a precharge and then an activate. During the access cycle, a steering stage routes write data, the column and a write strobe to the selected half, and it routes that half's read data back out. Requests are served one at a time and in order. A precharge-all input empties both halves.

Top module: `split_rowbuf_ctrl`

## Requirements
- R1: After reset, both halves are empty, `req_ready` is 1, and no command or done strobe is active. The first request to either class is therefore a miss.
- R2: A request whose class half is open on the same row is a hit. It issues no precharge and no activate, and `rsp_done` with `rsp_hit` comes 2 cycles after the accepting edge.
- R3: A request to an empty half is a miss. It issues one activate with `cmd_class` and `cmd_row` equal to the request, 2 cycles after acceptance, and no precharge. `rsp_done` comes 3 cycles after acceptance.
- R4: A request to a half open on a different row is a miss. It issues a precharge for that class 2 cycles after acceptance and an activate in the next cycle. `rsp_done` comes 4 cycles after acceptance.
- R5: A request of one class never changes the open state of the other class's half. A later request that returns to the other half's row still hits.
- R6: `req_ready` drops after an accepting edge and stays low until the cycle after `rsp_done`. Only one request is in flight at a time.
- R7: `pre_all` asserted while idle produces a one-cycle `cmd_pre_both` and empties both halves. It takes priority over a simultaneous `req_valid`, which is not accepted in that cycle.
- R8: In the `rsp_done` cycle, `buf_sel` equals the class (0 = fast-read, 1 = fast-write). `rdata` equals the selected half's read data. A write pulses only that half's write enable, with `buf_col` and `buf_wdata` taken from the request.
- R9: In the `rsp_done` cycle exactly one of `rsp_hit` and `rsp_miss` is 1. Outside it, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_class | input | 1 | Bit class: 0 fast-read, 1 fast-write |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write data |
| pre_all | input | 1 | Precharge both halves |
| cmd_pre | output | 1 | Precharge the half given by cmd_class |
| cmd_act | output | 1 | Activate cmd_row in the half given by cmd_class |
| cmd_pre_both | output | 1 | Precharge of both halves |
| cmd_class | output | 1 | Half addressed by the command |
| cmd_row | output | ROW_W | Row for the activate |
| rsp_done | output | 1 | Access cycle of the current request |
| rsp_hit | output | 1 | The request hit |
| rsp_miss | output | 1 | The request missed |
| buf_sel | output | 1 | Selected half during the access |
| buf_col | output | COL_W | Column to the selected half |
| buf_wdata | output | DATA_W | Write data to the selected half |
| fr_we | output | 1 | Write strobe, fast-read half |
| fw_we | output | 1 | Write strobe, fast-write half |
| fr_rdata | input | DATA_W | Read data from the fast-read half |
| fw_rdata | input | DATA_W | Read data from the fast-write half |
| rdata | output | DATA_W | Read data steered from the selected half |

## Verification
Suppose one half holds a wrong open row or a wrong valid flag. The next request to that class then shows a hit where a miss is due, or the reverse. This appears within 2 to 4 cycles of acceptance as a wrong `rsp_hit`, a missing or extra `cmd_pre`/`cmd_act`, or a shifted `rsp_done`. The sweep opens every pair of (class, row) combinations in turn and then returns to the first one. A tracker that disturbs the other half therefore fails on the third request of a pair. A steering fault shows in the same access cycle as wrong `rdata` or a strobe on the wrong half.

// File: rtl/srb_pkg.sv
package srb_pkg;

  localparam int NUM_HALF = 2;

  typedef enum logic {
    CLS_FR = 1'b0,
    CLS_FW = 1'b1
  } bit_class_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOOK = 3'd1,
    ST_PRE  = 3'd2,
    ST_ACT  = 3'd3,
    ST_ACC  = 3'd4,
    ST_PALL = 3'd5
  } srb_state_e;

endpackage

// File: rtl/srb_open_row.sv
// Open-row tracker for one half of the split buffer.
module srb_open_row #(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             clr,
  input  logic [ROW_W-1:0] new_row,
  output logic             open_valid,
  output logic [ROW_W-1:0] open_row
);

  logic             valid_q, valid_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    valid_d = valid_q;
    row_d   = row_q;
    if (clr) begin
      valid_d = 1'b0;
    end else if (upd) begin
      valid_d = 1'b1;
      row_d   = new_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else begin
      valid_q <= valid_d;
      row_q   <= row_d;
    end
  end

  assign open_valid = valid_q;
  assign open_row   = row_q;

  // R5: without an update or clear, the half keeps its state
  a_r5_half_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> ($stable(valid_q) && $stable(row_q)));

  // R7: a clear empties the half
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !valid_q);

endmodule

// File: rtl/srb_sequencer.sv
// One-request-at-a-time command sequencer.
module srb_sequencer
  import srb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic pre_all,
  input  logic lk_valid,
  input  logic lk_match,
  output logic req_ready,
  output logic accept,
  output logic cmd_pre,
  output logic cmd_act,
  output logic cmd_pre_both,
  output logic acc_cyc,
  output logic acc_hit
);

  srb_state_e state_q, state_d;
  logic       hit_q, hit_d;

  always_comb begin
    state_d = state_q;
    hit_d   = hit_q;
    case (state_q)
      ST_IDLE: begin
        if (pre_all)        state_d = ST_PALL;
        else if (req_valid) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        hit_d = lk_valid && lk_match;
        if (lk_valid && lk_match) state_d = ST_ACC;
        else if (lk_valid)        state_d = ST_PRE;
        else                      state_d = ST_ACT;
      end
      ST_PRE:  state_d = ST_ACT;
      ST_ACT:  state_d = ST_ACC;
      ST_ACC:  state_d = ST_IDLE;
      ST_PALL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hit_q   <= hit_d;
    end
  end

  assign req_ready    = (state_q == ST_IDLE) && !pre_all;
  assign accept       = req_valid && req_ready;
  assign cmd_pre      = (state_q == ST_PRE);
  assign cmd_act      = (state_q == ST_ACT);
  assign cmd_pre_both = (state_q == ST_PALL);
  assign acc_cyc      = (state_q == ST_ACC);
  assign acc_hit      = hit_q;

  // R4: a precharge is always followed by an activate
  a_r4_pre_then_act: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |=> cmd_act);

  // R3: an activate is followed by the access
  a_r3_act_then_access: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |=> acc_cyc);

  // R6: no second request accepted right after one
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/srb_steer.sv
// Data and strobe steering to the selected half.
module srb_steer #(
  parameter int COL_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              cls,
  input  logic              wr,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] fr_rdata,
  input  logic [DATA_W-1:0] fw_rdata,
  output logic              buf_sel,
  output logic [COL_W-1:0]  buf_col,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              fr_we,
  output logic              fw_we,
  output logic [DATA_W-1:0] rdata
);

  localparam int NH = srb_pkg::NUM_HALF;

  logic [NH-1:0]     we_vec;
  logic [DATA_W-1:0] rd_vec [NH];

  assign rd_vec[0] = fr_rdata;
  assign rd_vec[1] = fw_rdata;

  for (genvar g = 0; g < NH; g++) begin : g_we
    assign we_vec[g] = acc && wr && (cls == g[0]);
  end

  assign fr_we     = we_vec[0];
  assign fw_we     = we_vec[1];
  assign buf_sel   = cls;
  assign buf_col   = col;
  assign buf_wdata = wdata;
  assign rdata     = rd_vec[cls];

  // R8: at most one half written, and only in the access cycle
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fr_we, fw_we}) && ((fr_we || fw_we) -> acc));

endmodule

// File: rtl/split_rowbuf_ctrl.sv
module split_rowbuf_ctrl #(
  parameter int ROW_W  = 14,
  parameter int COL_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_class,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pre_all,
  output logic              cmd_pre,
  output logic              cmd_act,
  output logic              cmd_pre_both,
  output logic              cmd_class,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              rsp_done,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              buf_sel,
  output logic [COL_W-1:0]  buf_col,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              fr_we,
  output logic              fw_we,
  input  logic [DATA_W-1:0] fr_rdata,
  input  logic [DATA_W-1:0] fw_rdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int NH = srb_pkg::NUM_HALF;

  logic              accept, acc_cyc, acc_hit;
  logic              lat_cls_q, lat_cls_d, lat_wr_q, lat_wr_d;
  logic [ROW_W-1:0]  lat_row_q, lat_row_d;
  logic [COL_W-1:0]  lat_col_q, lat_col_d;
  logic [DATA_W-1:0] lat_wd_q, lat_wd_d;
  logic [NH-1:0]     half_valid;
  logic [ROW_W-1:0]  half_row [NH];
  logic              lk_valid, lk_match;

  // request capture, enabled by acceptance
  always_comb begin
    lat_cls_d = lat_cls_q;
    lat_wr_d  = lat_wr_q;
    lat_row_d = lat_row_q;
    lat_col_d = lat_col_q;
    lat_wd_d  = lat_wd_q;
    if (accept) begin
      lat_cls_d = req_class;
      lat_wr_d  = req_write;
      lat_row_d = req_row;
      lat_col_d = req_col;
      lat_wd_d  = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cls_q <= 1'b0;
      lat_wr_q  <= 1'b0;
      lat_row_q <= '0;
      lat_col_q <= '0;
      lat_wd_q  <= '0;
    end else begin
      lat_cls_q <= lat_cls_d;
      lat_wr_q  <= lat_wr_d;
      lat_row_q <= lat_row_d;
      lat_col_q <= lat_col_d;
      lat_wd_q  <= lat_wd_d;
    end
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    srb_open_row #(.ROW_W(ROW_W)) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd        (cmd_act && (lat_cls_q == g[0])),
      .clr        (cmd_pre_both),
      .new_row    (lat_row_q),
      .open_valid (half_valid[g]),
      .open_row   (half_row[g])
    );
  end

  assign lk_valid = half_valid[lat_cls_q];
  assign lk_match = (half_row[lat_cls_q] == lat_row_q);

  srb_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .pre_all      (pre_all),
    .lk_valid     (lk_valid),
    .lk_match     (lk_match),
    .req_ready    (req_ready),
    .accept       (accept),
    .cmd_pre      (cmd_pre),
    .cmd_act      (cmd_act),
    .cmd_pre_both (cmd_pre_both),
    .acc_cyc      (acc_cyc),
    .acc_hit      (acc_hit)
  );

  srb_steer #(.COL_W(COL_W), .DATA_W(DATA_W)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc_cyc),
    .cls       (lat_cls_q),
    .wr        (lat_wr_q),
    .col       (lat_col_q),
    .wdata     (lat_wd_q),
    .fr_rdata  (fr_rdata),
    .fw_rdata  (fw_rdata),
    .buf_sel   (buf_sel),
    .buf_col   (buf_col),
    .buf_wdata (buf_wdata),
    .fr_we     (fr_we),
    .fw_we     (fw_we),
    .rdata     (rdata)
  );

  assign cmd_class = lat_cls_q;
  assign cmd_row   = lat_row_q;
  assign rsp_done  = acc_cyc;
  assign rsp_hit   = acc_cyc && acc_hit;
  assign rsp_miss  = acc_cyc && !acc_hit;

  // R9: outcome flags exclusive and tied to the access cycle
  a_r9_outcome_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done -> (rsp_hit ^ rsp_miss)) && (!rsp_done -> !(rsp_hit || rsp_miss)));

  // R2: a hit is never preceded by an activate
  a_r2_hit_without_act: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !$past(rsp_done)) |-> !$past(cmd_act));

  // R7: precharge-all leaves both halves empty
  a_r7_both_empty: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_both |=> (half_valid == '0));

  // R3: an activate makes the addressed half open
  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |=> half_valid[$past(lat_cls_q)]);

endmodule

// File: tb/split_rowbuf_ctrl_tb.sv
module split_rowbuf_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 3;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] FR_PAT = 16'hA5C3;
  localparam logic [DATA_W-1:0] FW_PAT = 16'h3C5A;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready, req_class, req_write, pre_all;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic [DATA_W-1:0] req_wdata;
  logic              cmd_pre, cmd_act, cmd_pre_both, cmd_class;
  logic [ROW_W-1:0]  cmd_row;
  logic              rsp_done, rsp_hit, rsp_miss, buf_sel, fr_we, fw_we;
  logic [COL_W-1:0]  buf_col;
  logic [DATA_W-1:0] buf_wdata, rdata;
  logic [DATA_W-1:0] fr_rdata, fw_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic             m_valid [2];
  logic [ROW_W-1:0] m_row [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  split_rowbuf_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .req_wdata(req_wdata), .pre_all(pre_all),
    .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_pre_both(cmd_pre_both),
    .cmd_class(cmd_class), .cmd_row(cmd_row), .rsp_done(rsp_done),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .buf_sel(buf_sel),
    .buf_col(buf_col), .buf_wdata(buf_wdata), .fr_we(fr_we), .fw_we(fw_we),
    .fr_rdata(fr_rdata), .fw_rdata(fw_rdata), .rdata(rdata)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one request; expectations from the bench model
  task automatic do_req(input logic cls, input logic [ROW_W-1:0] row, input logic wr,
                        input logic [COL_W-1:0] col, input logic [DATA_W-1:0] wd);
    logic exp_hit, exp_pre;
    int   exp_lat, pre_at, act_at, cyc;
    logic busy_ok;
    exp_hit = m_valid[cls] && (m_row[cls] == row);
    exp_pre = !exp_hit && m_valid[cls];
    exp_lat = exp_hit ? 2 : (exp_pre ? 4 : 3);
    req_valid = 1'b1; req_class = cls; req_row = row; req_write = wr;
    req_col = col; req_wdata = wd;
    #1;
    chk(req_ready == 1'b1, "R6 ready before request", req_ready, 1);
    pre_at = 0; act_at = 0; cyc = 0; busy_ok = 1'b1;
    while (1) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (cyc == 1) req_valid = 1'b0;
      #1;
      if (cmd_pre) begin
        pre_at = cyc;
        chk(cmd_class == cls, "R4 precharge class", cmd_class, cls);
      end
      if (cmd_act) begin
        act_at = cyc;
        chk(cmd_class == cls && cmd_row == row, "R3 activate class/row",
            {cmd_class, cmd_row}, {cls, row});
      end
      if (req_ready) busy_ok = 1'b0;
      if (rsp_done || cyc > 8) break;
    end
    chk(busy_ok, "R6 ready low while busy", busy_ok, 1);
    chk(cyc == exp_lat, exp_hit ? "R2 hit latency" : (exp_pre ? "R4 conflict latency" : "R3 empty latency"),
        cyc, exp_lat);
    chk(rsp_hit == exp_hit && rsp_miss == !exp_hit, "R9 hit/miss flags",
        {rsp_hit, rsp_miss}, {exp_hit, !exp_hit});
    chk(exp_hit ? (pre_at == 0 && act_at == 0) : 1'b1, "R2 no commands on hit", {pre_at, act_at}, 0);
    chk(!exp_hit && !exp_pre ? (pre_at == 0 && act_at == 2) : 1'b1, "R3 activate only", {pre_at, act_at}, 2);
    chk(exp_pre ? (pre_at == 2 && act_at == 3) : 1'b1, "R4 precharge then activate", {pre_at, act_at}, {32'd2, 32'd3});
    chk(buf_sel == cls && rdata == (cls ? FW_PAT : FR_PAT), "R8 select and read data",
        {buf_sel, rdata}, {cls, (cls ? FW_PAT : FR_PAT)});
    if (wr)
      chk(fr_we == !cls && fw_we == cls && buf_col == col && buf_wdata == wd,
          "R8 write steering", {fr_we, fw_we, buf_col, buf_wdata}, {!cls, cls, col, wd});
    else
      chk(!fr_we && !fw_we, "R8 no strobe on read", {fr_we, fw_we}, 0);
    @(negedge clk); #1;
    chk(req_ready && !rsp_done && !rsp_hit && !rsp_miss, "R9 flags low after access",
        {req_ready, rsp_done, rsp_hit, rsp_miss}, 4'b1000);
    m_valid[cls] = 1'b1; m_row[cls] = row;
  endtask

  // precharge-all, optionally racing a request
  task automatic do_pall(input logic with_req);
    pre_all = 1'b1;
    req_valid = with_req; req_class = 1'b0; req_row = '0;
    #1;
    chk(!req_ready, "R7 ready masked by precharge-all", req_ready, 0);
    @(posedge clk); @(negedge clk);
    pre_all = 1'b0; req_valid = 1'b0;
    #1;
    chk(cmd_pre_both && !req_ready && !cmd_pre && !cmd_act, "R7 precharge-both pulse",
        {cmd_pre_both, req_ready}, 2'b10);
    @(negedge clk); #1;
    chk(!cmd_pre_both && req_ready && !rsp_done, "R7 single cycle, request not taken",
        {cmd_pre_both, req_ready, rsp_done}, 3'b010);
    m_valid[0] = 1'b0; m_valid[1] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_class = 1'b0; req_row = '0; req_col = '0;
    req_write = 1'b0; req_wdata = '0; pre_all = 1'b0;
    fr_rdata = FR_PAT; fw_rdata = FW_PAT;
    m_valid[0] = 1'b0; m_valid[1] = 1'b0; m_row[0] = '0; m_row[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(req_ready && !cmd_pre && !cmd_act && !cmd_pre_both && !rsp_done,
        "R1 reset outputs", {req_ready, cmd_pre, cmd_act, cmd_pre_both, rsp_done}, 5'b10000);
    // R1: first request of each class misses
    do_req(1'b1, 2'd3, 1'b0, 3'd1, 16'h0);
    do_req(1'b0, 2'd1, 1'b1, 3'd5, 16'h1234);
    // R5: both halves open together, each still hits
    do_req(1'b1, 2'd3, 1'b1, 3'd2, 16'hBEEF);
    do_req(1'b0, 2'd1, 1'b0, 3'd0, 16'h0);
    // R7: precharge-all wins over a request, then both miss
    do_pall(1'b1);
    do_req(1'b0, 2'd1, 1'b0, 3'd0, 16'h0);
    do_req(1'b1, 2'd3, 1'b0, 3'd0, 16'h0);
    // exhaustive pair sweep: open A, open B, revisit A (R5)
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        do_pall(1'b0);
        do_req(a[2], a[1:0], a[0], a[2:0], 16'(a * 37 + b));
        do_req(b[2], b[1:0], b[1], b[2:0], 16'(b * 91 + a));
        do_req(a[2], a[1:0], 1'b0, 3'd7, 16'h0);
      end
    end
    finish_run();
  end

endmodule